// File: doc/BRIEF.md
# PHY Reset and Power-Down Sequencer

This block decides when an Ethernet PHY's internal datapath is held in reset, when the device is powered down, and which management registers go back to their defaults in each case. Three things can start a reset: an active-low board pin, a power-on reset input, and a management write that sets the soft-reset bit of control register 0. Bit 11 of the same register powers the device down without resetting it.

The block holds control register 0 itself and answers its management writes. It drives a reset pulse to the datapath and a level that keeps the other management registers at their defaults. It also drives a power-down enable with two companion controls: one zeroes the MAC-side outputs and one tristates the line driver. A one-cycle strobe captures the management address from strap inputs. A per-bit vector tells the status registers which latching bits to reinitialise. The soft reset is short and self-clearing, it never powers the device down and it never re-reads the straps.

Top module: `phy_rst_pwr_ctrl`

## Requirements
- R1: Writing a word with bit 15 set to the control register (address `CTRL_ADDR`, default 0) asserts `dp_rst` and `regs_dflt` for exactly `SWRST_LEN` (default 2) cycles, starting with the cycle after the clock edge that accepts the write.
- R2: At the end of every reset, `ctrl_rdata` reads `CTRL_DEFAULT` with bit 15 forced to zero (default 0x3100). During a soft reset, bit 15 reads one. Once the soft reset ends, it reads zero.
- R3: During a soft reset, `pwr_dn_en`, `mac_out_zero` and `tx_tristate` stay low, even if the written word or the previous register value has bit 11 set.
- R4: When a pin or power-on reset ends, `addr_latch_stb` is high for one cycle and `phy_addr` then holds `strap_addr`. A soft reset leaves `addr_latch_stb` low and `phy_addr` unchanged.
- R5: `hw_rst_n` is active low and passes through a two-flop synchroniser. The second clock edge after the pin falls raises `dp_rst`, `regs_dflt` and `pwr_dn_en`. The second edge after it rises drops them. A pin or power-on reset never sets bit 15.
- R6: `pwr_dn_en` is high during a pin or power-on reset, and whenever bit 11 of the control register is one outside a soft reset. `mac_out_zero` and `tx_tristate` are high exactly when `pwr_dn_en` is.
- R7: While powered down through bit 11, `dp_rst` stays low and every other control-register bit keeps its value. `stat_reinit` equals LL_MASK|LH_MASK|LMX_MASK (default 0x54) whenever `pwr_dn_en` or `dp_rst` is high, and 0 otherwise.
- R8: Control-register writes made during any reset are ignored. A second soft-reset request during a soft reset does not restart the count.
- R9: Writes are still accepted while powered down through bit 11. A write that clears bit 11 drops `pwr_dn_en` on the next edge and does not pulse `dp_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, synchronous, active low; also resets the block's flops |
| hw_rst_n | input | 1 | Board reset pin, asynchronous, active low |
| mgmt_wr_en | input | 1 | Management register write strobe |
| mgmt_addr | input | ADDR_W | Management register address |
| mgmt_wdata | input | 16 | Management write data |
| strap_addr | input | ADDR_W | Strap-pin management address |
| ctrl_rdata | output | 16 | Current control register contents |
| phy_addr | output | ADDR_W | Latched management address |
| dp_rst | output | 1 | Datapath reset, active high |
| regs_dflt | output | 1 | Hold other management registers at defaults |
| pwr_dn_en | output | 1 | Power-down enable |
| mac_out_zero | output | 1 | Force MAC-side outputs to zero |
| tx_tristate | output | 1 | Tristate the twisted-pair transmitter |
| addr_latch_stb | output | 1 | One-cycle strobe to capture strap address |
| stat_reinit | output | STAT_W | Per-bit reinitialise for latching status bits |

## Verification
The bench builds the block with its defaults: a two-cycle soft reset, a two-stage synchroniser, eight status bits with latching masks 0x04, 0x10 and 0x40, and a register default of 0x3100. With these values, a write that lands on the second cycle of a soft reset can be placed deliberately. It also lets the bench separate the power-down level from the reset pulse, and see that bit 6 of the control register survives a bit-11 power-down but not any reset.

// File: rtl/phy_rst_pkg.sv
// Package: shared widths and control-register bit positions for the
// reset/power-down sequencer. The bit positions are decoded by software.
package phy_rst_pkg;
    localparam int CTRL_W    = 16;
    localparam int SWRST_BIT = 15;
    localparam int PDN_BIT   = 11;
    typedef logic [CTRL_W-1:0] ctrl_word_t;
endpackage

// File: rtl/prc_sync.sv
// Module: multi-stage synchroniser for an asynchronous level.
// Assumes: d is a slow level. Reset (synchronous, active low) clears the
// chain to zero, so an active-low input reads as asserted while in reset.
module prc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/prc_swrst_timer.sv
// Module: down-counter that times the soft reset.
// Assumes: start is never high while busy (the caller gates it).
// clear aborts the count, as a hard reset does.
module prc_swrst_timer #(
    parameter int LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic start,
    output logic busy,
    output logic last
);
    localparam int CW = $clog2(LEN + 1);
    logic [CW-1:0] cnt;

    // Load the length on start, then count down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)   cnt <= '0;
        else if (start)        cnt <= CW'(LEN);
        else if (cnt != '0)    cnt <= cnt - CW'(1);
    end

    assign busy = (cnt != '0);
    assign last = (cnt == CW'(1));
endmodule

// File: rtl/prc_ctrl_reg.sv
// Module: control register 0 with its soft-reset and power-down bits.
// Assumes: hold_dflt is high during pin/power-on reset and reload pulses
// on the final soft-reset cycle. lock blocks writes during any reset.
// The default value never has the soft-reset bit set.
module prc_ctrl_reg
    import phy_rst_pkg::*;
#(
    parameter ctrl_word_t            DFLT    = 16'h3100,
    parameter int                    ADDR_W  = 5,
    parameter logic [ADDR_W-1:0]     MY_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_dflt,
    input  logic              reload,
    input  logic              lock,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  ctrl_word_t        wdata,
    output ctrl_word_t        q,
    output logic              sw_req
);
    localparam ctrl_word_t DFLT_CLEAN = DFLT & ~(ctrl_word_t'(1) << SWRST_BIT);

    logic hit;

    // Accept a write only to this address and only outside any reset.
    assign hit    = wr_en && (addr == MY_ADDR) && !lock;
    assign sw_req = hit && wdata[SWRST_BIT];

    // Register update: defaults on any reset, otherwise take writes.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_dflt || reload) q <= DFLT_CLEAN;
        else if (hit)                      q <= wdata;
    end
endmodule

// File: rtl/prc_stat_reinit.sv
// Module: per-bit reinitialise vector for latching status bits.
// Assumes: the masks mark the latching-low, latching-high and
// latching-maximum bits. Other status bits are never reinitialised here.
module prc_stat_reinit #(
    parameter int                STAT_W   = 8,
    parameter logic [STAT_W-1:0] LL_MASK  = 8'h04,
    parameter logic [STAT_W-1:0] LH_MASK  = 8'h10,
    parameter logic [STAT_W-1:0] LMX_MASK = 8'h40
) (
    input  logic              en,
    output logic [STAT_W-1:0] reinit
);
    localparam logic [STAT_W-1:0] ANY_LATCH = LL_MASK | LH_MASK | LMX_MASK;

    // One control per status bit: latching bits follow en, others stay low.
    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (ANY_LATCH[i]) begin : g_latch
            assign reinit[i] = en;
        end else begin : g_plain
            assign reinit[i] = 1'b0;
        end
    end
endmodule

// File: rtl/phy_rst_pwr_ctrl.sv
// Module: reset and power-down sequencer for a PHY management block.
// Sources: power-on reset (por_n, synchronous), the board pin (hw_rst_n,
// synchronised) and the soft-reset bit. Power-down comes from a hard
// reset or from the power-down bit. A soft reset never powers down and
// never re-latches the strap address.
// Assumes: clk is the reference clock and por_n is held for at least one edge.
module phy_rst_pwr_ctrl
    import phy_rst_pkg::*;
#(
    parameter int                ADDR_W       = 5,
    parameter int                CTRL_ADDR    = 0,
    parameter ctrl_word_t        CTRL_DEFAULT = 16'h3100,
    parameter int                SWRST_LEN    = 2,
    parameter int                SYNC_STAGES  = 2,
    parameter int                STAT_W       = 8,
    parameter logic [STAT_W-1:0] LL_MASK      = 8'h04,
    parameter logic [STAT_W-1:0] LH_MASK      = 8'h10,
    parameter logic [STAT_W-1:0] LMX_MASK     = 8'h40
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              hw_rst_n,
    input  logic              mgmt_wr_en,
    input  logic [ADDR_W-1:0] mgmt_addr,
    input  logic [CTRL_W-1:0] mgmt_wdata,
    input  logic [ADDR_W-1:0] strap_addr,
    output logic [CTRL_W-1:0] ctrl_rdata,
    output logic [ADDR_W-1:0] phy_addr,
    output logic              dp_rst,
    output logic              regs_dflt,
    output logic              pwr_dn_en,
    output logic              mac_out_zero,
    output logic              tx_tristate,
    output logic              addr_latch_stb,
    output logic [STAT_W-1:0] stat_reinit
);
    logic       pin_sync;
    logic       hard_now;
    logic       hard_q;
    logic       sw_req;
    logic       sw_busy;
    logic       sw_last;
    logic       any_rst;
    ctrl_word_t ctrl_q;

    prc_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d     (hw_rst_n),
        .q     (pin_sync)
    );

    // The pin reset, or power-on reset through the cleared synchroniser.
    assign hard_now = !pin_sync;

    prc_swrst_timer #(.LEN(SWRST_LEN)) u_sw_timer (
        .clk   (clk),
        .rst_n (por_n),
        .clear (hard_now),
        .start (sw_req),
        .busy  (sw_busy),
        .last  (sw_last)
    );

    prc_ctrl_reg #(
        .DFLT    (CTRL_DEFAULT),
        .ADDR_W  (ADDR_W),
        .MY_ADDR (ADDR_W'(CTRL_ADDR))
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (por_n),
        .hold_dflt (hard_now),
        .reload    (sw_last),
        .lock      (any_rst),
        .wr_en     (mgmt_wr_en),
        .addr      (mgmt_addr),
        .wdata     (mgmt_wdata),
        .q         (ctrl_q),
        .sw_req    (sw_req)
    );

    // Remember the previous hard-reset level to find its release.
    always_ff @(posedge clk) begin
        if (!por_n) hard_q <= 1'b1;
        else        hard_q <= hard_now;
    end

    assign addr_latch_stb = hard_q && !hard_now;

    // Capture the strap address on hard-reset release only.
    always_ff @(posedge clk) begin
        if (!por_n)              phy_addr <= '0;
        else if (addr_latch_stb) phy_addr <= strap_addr;
    end

    assign any_rst      = hard_now || sw_busy;
    assign dp_rst       = any_rst;
    assign regs_dflt    = any_rst;
    assign pwr_dn_en    = hard_now || (ctrl_q[PDN_BIT] && !sw_busy);
    assign mac_out_zero = pwr_dn_en;
    assign tx_tristate  = pwr_dn_en;
    assign ctrl_rdata   = ctrl_q;

    prc_stat_reinit #(
        .STAT_W   (STAT_W),
        .LL_MASK  (LL_MASK),
        .LH_MASK  (LH_MASK),
        .LMX_MASK (LMX_MASK)
    ) u_stat (
        .en     (pwr_dn_en || any_rst),
        .reinit (stat_reinit)
    );
endmodule

// File: rtl/prc_chk.sv
// Module: property checker for phy_rst_pwr_ctrl, attached by bind below.
// Assumes: sampled on the reference clock; disabled while por_n is low.
module prc_chk
    import phy_rst_pkg::*;
#(
    parameter int                STAT_W    = 8,
    parameter logic [STAT_W-1:0] LAT_MASK  = 8'h54
) (
    input logic              clk,
    input logic              por_n,
    input logic              hw_rst_n,
    input logic              hard_now,
    input logic              sw_req,
    input logic              sw_busy,
    input logic              dp_rst,
    input logic              pwr_dn_en,
    input logic [CTRL_W-1:0] ctrl_rdata,
    input logic [4:0]        phy_addr,
    input logic              addr_latch_stb,
    input logic [STAT_W-1:0] stat_reinit
);
    // Soft reset spans exactly two cycles (default length).
    assert_swrst_len_R1: assert property (@(posedge clk) disable iff (!por_n || hard_now)
        sw_req |=> dp_rst ##1 dp_rst ##1 !dp_rst);

    assert_swbit_clear_R2: assert property (@(posedge clk) disable iff (!por_n)
        $fell(sw_busy) |-> !ctrl_rdata[SWRST_BIT]);

    assert_no_pdn_in_swrst_R3: assert property (@(posedge clk) disable iff (!por_n)
        (sw_busy && !hard_now) |-> !pwr_dn_en);

    assert_no_relatch_R4: assert property (@(posedge clk) disable iff (!por_n)
        !addr_latch_stb |=> $stable(phy_addr));

    assert_pin_reset_R5: assert property (@(posedge clk) disable iff (!por_n)
        !$past(hw_rst_n, 2) |-> (dp_rst && pwr_dn_en));

    assert_bitpdn_reinit_R7: assert property (@(posedge clk) disable iff (!por_n)
        (ctrl_rdata[PDN_BIT] && !dp_rst) |-> (pwr_dn_en && stat_reinit == LAT_MASK));

    assert_no_restart_R8: assert property (@(posedge clk) disable iff (!por_n)
        sw_busy |-> !sw_req);

    assert_frozen_in_swrst_R8: assert property (@(posedge clk) disable iff (!por_n || hard_now)
        (sw_busy && $past(sw_busy) && !$past(hard_now)) |-> $stable(ctrl_rdata));

    assert_pdn_release_R9: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(ctrl_rdata[PDN_BIT]) && !dp_rst) |-> !pwr_dn_en);
endmodule

bind phy_rst_pwr_ctrl prc_chk #(
    .STAT_W   (STAT_W),
    .LAT_MASK (LL_MASK | LH_MASK | LMX_MASK)
) chk_i (
    .clk            (clk),
    .por_n          (por_n),
    .hw_rst_n       (hw_rst_n),
    .hard_now       (hard_now),
    .sw_req         (sw_req),
    .sw_busy        (sw_busy),
    .dp_rst         (dp_rst),
    .pwr_dn_en      (pwr_dn_en),
    .ctrl_rdata     (ctrl_rdata),
    .phy_addr       (phy_addr),
    .addr_latch_stb (addr_latch_stb),
    .stat_reinit    (stat_reinit)
);

// File: tb/phy_rst_pwr_ctrl_tb_top.sv
// Directed bench: one task per scenario. Inputs are driven and outputs
// sampled on the falling clock edge.
module phy_rst_pwr_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        hw_rst_n = 1'b1;
    logic        mgmt_wr_en = 1'b0;
    logic [4:0]  mgmt_addr = '0;
    logic [15:0] mgmt_wdata = '0;
    logic [4:0]  strap_addr = 5'h05;
    logic [15:0] ctrl_rdata;
    logic [4:0]  phy_addr;
    logic        dp_rst, regs_dflt, pwr_dn_en, mac_out_zero, tx_tristate, addr_latch_stb;
    logic [7:0]  stat_reinit;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [15:0] DFLT = 16'h3100;
    localparam logic [7:0]  LATM = 8'h54;

    always #10 clk = ~clk;

    phy_rst_pwr_ctrl dut_i (
        .clk(clk), .por_n(por_n), .hw_rst_n(hw_rst_n),
        .mgmt_wr_en(mgmt_wr_en), .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata),
        .strap_addr(strap_addr), .ctrl_rdata(ctrl_rdata), .phy_addr(phy_addr),
        .dp_rst(dp_rst), .regs_dflt(regs_dflt), .pwr_dn_en(pwr_dn_en),
        .mac_out_zero(mac_out_zero), .tx_tristate(tx_tristate),
        .addr_latch_stb(addr_latch_stb), .stat_reinit(stat_reinit)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // One management write; returns after the accepting edge.
    task automatic mwrite(input logic [15:0] w);
        mgmt_wr_en = 1'b1; mgmt_addr = 5'd0; mgmt_wdata = w;
        step();
        mgmt_wr_en = 1'b0;
    endtask

    // Power-on reset release: reset state, strobe, strap latch.
    task automatic t_por();
        step(); step();
        por_n = 1'b1;
        step();
        check("R5 dp_rst after por", {31'b0, dp_rst}, 1);
        check("R6 pwr_dn_en after por", {31'b0, pwr_dn_en}, 1);
        check("R2 ctrl default", {16'b0, ctrl_rdata}, {16'b0, DFLT});
        check("R7 reinit in reset", {24'b0, stat_reinit}, {24'b0, LATM});
        step();
        check("R5 dp_rst released", {31'b0, dp_rst}, 0);
        check("R4 strobe high", {31'b0, addr_latch_stb}, 1);
        step();
        check("R4 strobe one cycle", {31'b0, addr_latch_stb}, 0);
        check("R4 strap latched", {27'b0, phy_addr}, 32'h05);
        check("R7 reinit idle", {24'b0, stat_reinit}, 0);
    endtask

    // Power-down through bit 11, writes while down, release.
    task automatic t_pdn();
        mwrite(16'h0840);
        check("R6 pdn via bit", {31'b0, pwr_dn_en}, 1);
        check("R6 mac zero", {31'b0, mac_out_zero}, 1);
        check("R6 tx tristate", {31'b0, tx_tristate}, 1);
        check("R7 no dp_rst", {31'b0, dp_rst}, 0);
        check("R7 reinit mask", {24'b0, stat_reinit}, {24'b0, LATM});
        check("R7 bits kept", {16'b0, ctrl_rdata}, 32'h0840);
        mwrite(16'h0841);
        check("R9 write while down", {16'b0, ctrl_rdata}, 32'h0841);
        mwrite(16'h0041);
        check("R9 pdn released", {31'b0, pwr_dn_en}, 0);
        check("R9 no reset pulse", {31'b0, dp_rst}, 0);
        check("R9 tx released", {31'b0, tx_tristate}, 0);
    endtask

    // Soft reset with bit 11 set, a retry during it, and new straps.
    task automatic t_swrst();
        strap_addr = 5'h0A;
        mgmt_wr_en = 1'b1; mgmt_addr = 5'd0; mgmt_wdata = 16'h8840;
        step();
        mgmt_wdata = 16'h8800;
        check("R1 dp_rst cycle1", {31'b0, dp_rst}, 1);
        check("R1 regs_dflt cycle1", {31'b0, regs_dflt}, 1);
        check("R2 bit15 reads one", {31'b0, ctrl_rdata[15]}, 1);
        check("R3 no pdn in swrst", {31'b0, pwr_dn_en}, 0);
        check("R3 no tristate in swrst", {31'b0, tx_tristate}, 0);
        step();
        mgmt_wr_en = 1'b0;
        check("R1 dp_rst cycle2", {31'b0, dp_rst}, 1);
        check("R4 no strobe in swrst", {31'b0, addr_latch_stb}, 0);
        step();
        check("R8 not restarted", {31'b0, dp_rst}, 0);
        check("R2 default after swrst", {16'b0, ctrl_rdata}, {16'b0, DFLT});
        check("R8 write ignored", {31'b0, pwr_dn_en}, 0);
        check("R4 no relatch", {27'b0, phy_addr}, 32'h05);
    endtask

    // Pin reset: sync delay, defaults, ignored writes, strap latch.
    task automatic t_hard();
        mwrite(16'h0040);
        strap_addr = 5'h13;
        hw_rst_n = 1'b0;
        step();
        check("R5 sync delay", {31'b0, dp_rst}, 0);
        step();
        check("R5 dp_rst on pin", {31'b0, dp_rst}, 1);
        check("R5 pdn on pin", {31'b0, pwr_dn_en}, 1);
        check("R5 regs_dflt on pin", {31'b0, regs_dflt}, 1);
        mwrite(16'h8000);
        check("R8 write ignored in hard", {16'b0, ctrl_rdata}, {16'b0, DFLT});
        check("R5 bit15 never set", {31'b0, ctrl_rdata[15]}, 0);
        hw_rst_n = 1'b1;
        step();
        check("R5 still in reset", {31'b0, dp_rst}, 1);
        step();
        check("R5 release", {31'b0, dp_rst}, 0);
        check("R4 strobe on release", {31'b0, addr_latch_stb}, 1);
        step();
        check("R4 new strap", {27'b0, phy_addr}, 32'h13);
        check("R1 no soft reset left", {31'b0, dp_rst}, 0);
    endtask

    initial begin
        t_por();
        t_pdn();
        t_swrst();
        t_hard();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule